// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is a programmable down-counter advanced by a 100 Hz enable pulse. A host loads a four-digit BCD period of 0.01 s to 99.99 s, in 0.01 s steps, through two byte-wide reload registers. When the count runs out, the block sets a sticky flag, drives an interrupt and reloads itself. In interval mode it fires at a fixed rate. In watchdog mode any host access to the block restarts the count, so the interrupt is raised only if the host stops servicing it.

The timer flag and an externally supplied time-of-day alarm flag share two interrupt outputs. A control bit chooses which output carries the timer and which carries the alarm. The first output is always active-low. The second has a selectable polarity. Reading the control/status register clears the timer flag. Counting depends only on the tick input, so the block keeps running whatever the state of the main supply.

Top module: `wdt_interval_top`

## Requirements
- R1: After reset, both reload bytes and the control bits read 0, the timer flag is clear, `irq_a_n` is 1 and `irq_b` is 1.
- R2: The period is stored in BCD. Address 0 holds tenths in bits [7:4] and hundredths in bits [3:0]. Address 1 holds tens of seconds in [7:4] and seconds in [3:0]. With period N, the flag rises on the Nth tick after a restart and not before.
- R3: When the flag is set, the count reloads automatically, so the next expiry comes N ticks later.
- R4: A write to either reload byte restarts the count from the full new period.
- R5: A period of zero disables the timer: no tick ever sets the flag.
- R6: A read of address 2 returns the timer flag in bit 7. That read clears the flag after the read cycle. The flag otherwise stays set.
- R7: With control bit 2 set (watchdog mode), any access to any address restarts the count. With bit 2 clear (interval mode), reads and control writes do not.
- R8: With control bit 0 clear, the timer flag drives output A and the alarm drives output B. With bit 0 set, the two are swapped.
- R9: `irq_a_n` is always active-low. `irq_b` is active-high when control bit 1 is set and active-low when it is clear.
- R10: The `tod_alarm` input reads back in bit 6 of address 2. Address 2 also returns the control bits in [2:0].
- R11: With `tick` low and no restart, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 100 Hz count enable |
| cs | input | 1 | Host access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| tod_alarm | input | 1 | Time-of-day alarm flag |
| irq_a_n | output | 1 | Interrupt A, active-low |
| irq_b | output | 1 | Interrupt B, programmable polarity |

## Verification
The bench sweeps periods 1 to 30 and the digit-rollover values 99, 100, 101, 999, 1000, 1234 and 9999. A borrow chain that mishandles a digit crossing zero would fire early or late on one of these. It checks one tick before and at expiry, then repeats the check after the automatic reload, so an off-by-one or a lost reload shows up at once. Service accesses are placed one tick before expiry in both modes. This catches a timer that restarts in the wrong mode. The bench then walks all four routing and polarity settings with the alarm both high and low, which exposes a swapped or inverted output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WDT_DIGITS  = 4;
    localparam int WDT_DATA_W  = 8;
    localparam int WDT_ADDR_W  = 2;
    localparam int WDT_DIG_PER_BYTE = WDT_DATA_W / 4;

    typedef logic [WDT_DIGITS-1:0][3:0] bcd_t;

    typedef enum logic [WDT_ADDR_W-1:0] {
        ADDR_RLD_LO = 2'd0,
        ADDR_RLD_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_SPARE  = 2'd3
    } wdt_addr_e;

    typedef struct packed {
        logic wd_mode;
        logic pol_b_high;
        logic route_b;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);
    localparam int STAT_FLAG_BIT  = WDT_DATA_W - 1;
    localparam int STAT_ALARM_BIT = WDT_DATA_W - 2;

    function automatic logic bcd_is_zero(input bcd_t v);
        return v == '0;
    endfunction

    function automatic logic bcd_is_one(input bcd_t v);
        return (v[0] == 4'd1) && (v[WDT_DIGITS-1:1] == '0);
    endfunction

    function automatic logic [3:0] bcd_digit_dec(input logic [3:0] d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

endpackage

// File: rtl/wdt_bcd_down.sv
module wdt_bcd_down
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  bcd_t load_val,
    input  logic tick,
    input  bcd_t reload_val,
    output bcd_t cnt_o,
    output logic expire_o
);

    bcd_t cnt_q;
    bcd_t cnt_dec;
    logic [WDT_DIGITS:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < WDT_DIGITS; i++) begin : g_digit
        assign cnt_dec[i]    = borrow[i] ? bcd_digit_dec(cnt_q[i]) : cnt_q[i];
        assign borrow[i + 1] = borrow[i] && (cnt_q[i] == 4'd0);
    end

    logic run;
    assign run      = tick && !load && !bcd_is_zero(reload_val);
    assign expire_o = run && bcd_is_one(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run) begin
            cnt_q <= bcd_is_one(cnt_q) ? reload_val : cnt_dec;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_irq_route.sv
module wdt_irq_route
    import wdt_pkg::*;
(
    input  logic      timer_flag,
    input  logic      alarm_flag,
    input  wdt_ctrl_t ctrl,
    output logic      irq_a_n,
    output logic      irq_b
);

    logic src_a, src_b;

    always_comb begin
        if (ctrl.route_b) begin
            src_a = alarm_flag;
            src_b = timer_flag;
        end else begin
            src_a = timer_flag;
            src_b = alarm_flag;
        end
        irq_a_n = ~src_a;
        irq_b   = ctrl.pol_b_high ? src_b : ~src_b;
    end

endmodule

// File: rtl/wdt_interval_top.sv
module wdt_interval_top
    import wdt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cs,
    input  logic                  we,
    input  logic [WDT_ADDR_W-1:0] addr,
    input  logic [WDT_DATA_W-1:0] wdata,
    output logic [WDT_DATA_W-1:0] rdata,
    input  logic                  tod_alarm,
    output logic                  irq_a_n,
    output logic                  irq_b
);

    localparam int LO_TOP = WDT_DIG_PER_BYTE - 1;
    localparam int HI_BOT = WDT_DIG_PER_BYTE;
    localparam int HI_TOP = WDT_DIGITS - 1;

    wdt_addr_e addr_e;
    assign addr_e = wdt_addr_e'(addr);

    logic wr, rd, wr_reload, rd_status, restart, expire;
    bcd_t reload_q, reload_nx, cnt;
    wdt_ctrl_t ctrl_q;
    logic flag_q;

    assign wr        = cs && we;
    assign rd        = cs && !we;
    assign wr_reload = wr && (addr_e == ADDR_RLD_LO || addr_e == ADDR_RLD_HI);
    assign rd_status = rd && (addr_e == ADDR_CTRL);
    assign restart   = wr_reload || (ctrl_q.wd_mode && cs);

    always_comb begin
        reload_nx = reload_q;
        if (wr && addr_e == ADDR_RLD_LO) reload_nx[LO_TOP:0]      = wdata;
        if (wr && addr_e == ADDR_RLD_HI) reload_nx[HI_TOP:HI_BOT] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            reload_q <= reload_nx;
            if (wr && addr_e == ADDR_CTRL) ctrl_q <= wdt_ctrl_t'(wdata[CTRL_W-1:0]);
            if (expire)         flag_q <= 1'b1;
            else if (rd_status) flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr_e)
            ADDR_RLD_LO: rdata = reload_q[LO_TOP:0];
            ADDR_RLD_HI: rdata = reload_q[HI_TOP:HI_BOT];
            ADDR_CTRL: begin
                rdata[STAT_FLAG_BIT]  = flag_q;
                rdata[STAT_ALARM_BIT] = tod_alarm;
                rdata[CTRL_W-1:0]     = ctrl_q;
            end
            default: rdata = '0;
        endcase
    end

    wdt_bcd_down u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (restart),
        .load_val   (reload_nx),
        .tick       (tick),
        .reload_val (reload_q),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    wdt_irq_route u_route (
        .timer_flag (flag_q),
        .alarm_flag (tod_alarm),
        .ctrl       (ctrl_q),
        .irq_a_n    (irq_a_n),
        .irq_b      (irq_b)
    );

endmodule

// File: rtl/wdt_interval_chk.sv
module wdt_interval_chk
    import wdt_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input logic      restart,
    input logic      rd_status,
    input logic      flag_q,
    input bcd_t      cnt,
    input bcd_t      reload_q,
    input logic      tod_alarm,
    input wdt_ctrl_t ctrl_q,
    input logic      irq_a_n,
    input logic      irq_b
);

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt));

    assert_flag_rises_at_one_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(cnt[0]) == 4'd1 && $past(cnt[WDT_DIGITS-1:1]) == '0));

    assert_zero_period_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (reload_q == '0 && !flag_q) |=> !flag_q);

    assert_status_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !(tick && cnt[0] == 4'd1 && cnt[WDT_DIGITS-1:1] == '0)) |=> !flag_q);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !rd_status) |=> flag_q);

    assert_out_a_low_R9: assert property (@(posedge clk) disable iff (rst)
        irq_a_n == !(ctrl_q.route_b ? tod_alarm : flag_q));

    assert_out_b_pol_R8: assert property (@(posedge clk) disable iff (rst)
        irq_b == ((ctrl_q.route_b ? flag_q : tod_alarm) == ctrl_q.pol_b_high));

endmodule

bind wdt_interval_top wdt_interval_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (restart),
    .rd_status (rd_status),
    .flag_q    (flag_q),
    .cnt       (cnt),
    .reload_q  (reload_q),
    .tod_alarm (tod_alarm),
    .ctrl_q    (ctrl_q),
    .irq_a_n   (irq_a_n),
    .irq_b     (irq_b)
);

// File: tb/wdt_interval_top_tb_top.sv
`timescale 1ns/100ps
module wdt_interval_top_tb_top;

    logic clk = 1'b0;
    logic rst, tick, cs, we, tod_alarm;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic irq_a_n, irq_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    wdt_interval_top dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tod_alarm(tod_alarm),
        .irq_a_n(irq_a_n), .irq_b(irq_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    function automatic logic [15:0] to_bcd(input int n);
        return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
    endfunction

    task automatic set_period(input int n);
        logic [15:0] b;
        b = to_bcd(n);
        wr(2'd0, b[7:0]);
        wr(2'd1, b[15:8]);
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        rd(2'd2, d);
    endtask

    task automatic run_period(input int n);
        logic [7:0] d;
        set_period(n);
        ticks(n - 1);
        check(irq_a_n == 1'b1, "R2 early", irq_a_n, 1);
        ticks(1);
        check(irq_a_n == 1'b0, "R2 expiry", irq_a_n, 0);
        rd(2'd2, d);
        check(d[7] == 1'b1, "R6 flag bit", d[7], 1);
        check(irq_a_n == 1'b1, "R6 cleared", irq_a_n, 1);
        ticks(n - 1);
        check(irq_a_n == 1'b1, "R3 early", irq_a_n, 1);
        ticks(1);
        check(irq_a_n == 1'b0, "R3 reload expiry", irq_a_n, 0);
        clear_flag();
    endtask

    initial begin
        #(5 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int sweep [7] = '{99, 100, 101, 999, 1000, 1234, 9999};
        rst = 1'b1; tick = 0; cs = 0; we = 0; addr = 0; wdata = 0; tod_alarm = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check(d == 8'h00, "R1 lo", d, 0);
        rd(2'd1, d); check(d == 8'h00, "R1 hi", d, 0);
        rd(2'd2, d); check(d == 8'h00, "R1 status", d, 0);
        check(irq_a_n == 1'b1 && irq_b == 1'b1, "R1 irq", {irq_a_n, irq_b}, 3);

        // R5 zero period
        ticks(200);
        check(irq_a_n == 1'b1, "R5 irq", irq_a_n, 1);
        rd(2'd2, d); check(d[7] == 1'b0, "R5 flag", d[7], 0);

        // R2/R3/R6 sweep
        for (int n = 1; n <= 30; n++) run_period(n);
        foreach (sweep[k]) run_period(sweep[k]);
        rd(2'd1, d); check(d == 8'h99, "R2 hi readback", d, 8'h99);

        // R4 restart by reload write
        set_period(5);
        ticks(3);
        wr(2'd1, 8'h00);
        ticks(4);
        check(irq_a_n == 1'b1, "R4 restarted", irq_a_n, 1);
        ticks(1);
        check(irq_a_n == 1'b0, "R4 expiry", irq_a_n, 0);
        clear_flag();

        // R11 hold without tick
        set_period(3);
        repeat (10) @(negedge clk);
        ticks(2);
        check(irq_a_n == 1'b1, "R11 held", irq_a_n, 1);
        ticks(1);
        check(irq_a_n == 1'b0, "R11 expiry", irq_a_n, 0);
        clear_flag();

        // R7 interval mode: read does not restart
        set_period(5);
        ticks(4);
        rd(2'd0, d);
        ticks(1);
        check(irq_a_n == 1'b0, "R7 interval no service", irq_a_n, 0);
        clear_flag();

        // R7 watchdog mode: any access services
        wr(2'd2, 8'h04);
        set_period(5);
        ticks(4);
        rd(2'd0, d);
        ticks(4);
        check(irq_a_n == 1'b1, "R7 serviced", irq_a_n, 1);
        ticks(1);
        check(irq_a_n == 1'b0, "R7 bite", irq_a_n, 0);
        rd(2'd2, d);
        check(d[7] == 1'b1 && d[2:0] == 3'b100, "R10 ctrl readback", d, 8'h84);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        clear_flag();

        // R10/R8/R9 routing and polarity
        tod_alarm = 1'b1;
        @(negedge clk);
        rd(2'd2, d); check(d[6] == 1'b1, "R10 alarm bit", d[6], 1);
        check(irq_a_n == 1'b1 && irq_b == 1'b0, "R10 alarm on B low", {irq_a_n, irq_b}, 2);
        wr(2'd2, 8'h02);
        check(irq_b == 1'b1, "R9 B active-high", irq_b, 1);
        wr(2'd2, 8'h03);
        check(irq_a_n == 1'b0, "R8 alarm on A", irq_a_n, 0);
        check(irq_b == 1'b0, "R8 B idle high-pol", irq_b, 0);
        tod_alarm = 1'b0;
        set_period(2);
        ticks(2);
        check(irq_b == 1'b1 && irq_a_n == 1'b1, "R8 timer on B", {irq_a_n, irq_b}, 3);
        wr(2'd2, 8'h01);
        check(irq_b == 1'b0, "R9 B active-low", irq_b, 0);
        clear_flag();
        check(irq_b == 1'b1, "R9 B idle", irq_b, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule